// File: doc/BRIEF.md
# Timer Event Interrupt and Wakeup Controller

This block gathers the three event sources of a general purpose timer (compare hit, counter wrap and input capture) and turns them into a level interrupt and a one-cycle wakeup pulse. The counter core and the capture unit deliver events as single-cycle pulses. Software programs two enable masks and services a sticky flag register over a simple address/data port.

A flag latches only when its event is enabled for interrupts. The wakeup path does not go through the flags: any event whose wakeup mask bit is set produces a pulse, whatever the interrupt mask holds. Software clears flags by writing ones. Clearing the capture flag also sends a strobe that tells the capture unit to restart its capture sequence count from zero.

Top module: `tmrevt_top`

## Requirements
- R1: After reset the flag register and both mask registers read 0, and `irqOut`, `wakePulse` and `captRearm` are low.
- R2: Event bit i (bit 0 = compare hit, bit 1 = counter wrap, bit 2 = capture) sets flag bit i at the clock edge that samples the event only when interrupt mask bit i is 1. Otherwise the flag bit stays unchanged.
- R3: `irqOut` is high exactly in the cycles in which the flag register is non-zero, and it changes at the same edge as the flags.
- R4: A write to the flag register clears each flag written as 1 and leaves the flags written as 0 unchanged. `irqOut` drops at the edge where the flags become zero.
- R5: A write to the flag register with data bit 2 set produces `captRearm` high for exactly the one cycle that follows the write edge. A flag write with bit 2 clear produces no pulse.
- R6: `wakePulse` is high for one cycle after any edge that samples an event whose wakeup mask bit is 1, independent of the interrupt mask. It leaves the flags untouched.
- R7: Writes to the interrupt mask and the wakeup mask keep only data bits 2:0. The upper bits read back as 0.
- R8: When an event and a clearing write hit the same flag at one edge, the event wins and the flag stays set.
- R9: The register offsets are: flags at 0x0, interrupt mask at 0x4, wakeup mask at 0x8. Reads of any other offset return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtIn | input | EVT_W (3) | Single-cycle event pulses: bit0 compare, bit1 wrap, bit2 capture |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | ADDR_W (4) | Register byte offset |
| busWrData | input | DATA_W (32) | Write data |
| busRdData | output | DATA_W (32) | Combinational read data for busAddr |
| irqOut | output | 1 | Level interrupt |
| wakePulse | output | 1 | One-cycle wakeup pulse |
| captRearm | output | 1 | One-cycle strobe that restarts the capture sequence count |

## Verification
The bench builds the block with its default parameters: three event bits, a 4-bit address and 32-bit data. With three event bits, every pair of interrupt mask and event pattern (64 in all) can be run. A wakeup mask derived from each interrupt mask is applied at the same time, so the enabled, masked, wakeup-only and interrupt-only cases all occur. The short address space also lets the bench reach the unmapped offset, and the clear, rearm and collision cases are directed on top of that.

// File: rtl/tmrevt_pkg.sv
package tmrevt_pkg;
  // Byte offsets of the three registers
  localparam int unsigned STAT_OFS = 0;
  localparam int unsigned IEN_OFS  = 4;
  localparam int unsigned WEN_OFS  = 8;
  // Event bit whose clearing restarts the capture sequence
  localparam int unsigned CAPT_BIT = 2;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_STAT = 2'd1,
    SEL_IEN  = 2'd2,
    SEL_WEN  = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic   wrStat;
    logic   wrIen;
    logic   wrWen;
    rdSel_e rdSel;
  } strobe_t;
endpackage

// File: rtl/tmrevt_ctrl.sv
module tmrevt_ctrl
  import tmrevt_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           strb
);
  logic hitStat, hitIen, hitWen;

  always_comb begin
    hitStat = (busAddr == ADDR_W'(STAT_OFS));
    hitIen  = (busAddr == ADDR_W'(IEN_OFS));
    hitWen  = (busAddr == ADDR_W'(WEN_OFS));
    strb.wrStat = busWrEn & hitStat;
    strb.wrIen  = busWrEn & hitIen;
    strb.wrWen  = busWrEn & hitWen;
    if (hitStat)     strb.rdSel = SEL_STAT;
    else if (hitIen) strb.rdSel = SEL_IEN;
    else if (hitWen) strb.rdSel = SEL_WEN;
    else             strb.rdSel = SEL_NONE;
  end
endmodule

// File: rtl/tmrevt_datapath.sv
module tmrevt_datapath
  import tmrevt_pkg::*;
#(
  parameter int unsigned EVT_W  = 3,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [EVT_W-1:0]  evtIn,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut,
  output logic              wakePulse,
  output logic              captRearm,
  output logic [EVT_W-1:0]  statusQ,
  output logic [EVT_W-1:0]  irqEnQ,
  output logic [EVT_W-1:0]  wakeEnQ
);
  logic [EVT_W-1:0] statusNext;
  logic [EVT_W-1:0] clrMask;

  assign clrMask = strb.wrStat ? wrData[EVT_W-1:0] : '0;

  // One flag per event source; a new event overrides a clear
  for (genvar i = 0; i < EVT_W; i++) begin : g_flag
    always_comb begin
      if (evtIn[i] && irqEnQ[i]) statusNext[i] = 1'b1;
      else if (clrMask[i])       statusNext[i] = 1'b0;
      else                       statusNext[i] = statusQ[i];
    end
    always_ff @(posedge clk) begin
      if (!rstN) statusQ[i] <= 1'b0;
      else       statusQ[i] <= statusNext[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqEnQ    <= '0;
      wakeEnQ   <= '0;
      irqOut    <= 1'b0;
      wakePulse <= 1'b0;
      captRearm <= 1'b0;
    end else begin
      if (strb.wrIen) irqEnQ  <= wrData[EVT_W-1:0];
      if (strb.wrWen) wakeEnQ <= wrData[EVT_W-1:0];
      irqOut    <= |statusNext;
      wakePulse <= |(evtIn & wakeEnQ);
      captRearm <= strb.wrStat & wrData[CAPT_BIT];
    end
  end

  always_comb begin
    case (strb.rdSel)
      SEL_STAT: rdData = DATA_W'(statusQ);
      SEL_IEN:  rdData = DATA_W'(irqEnQ);
      SEL_WEN:  rdData = DATA_W'(wakeEnQ);
      default:  rdData = '0;
    endcase
  end
endmodule

// File: rtl/tmrevt_top.sv
module tmrevt_top
  import tmrevt_pkg::*;
#(
  parameter int unsigned EVT_W  = 3,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [EVT_W-1:0]  evtIn,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              irqOut,
  output logic              wakePulse,
  output logic              captRearm
);
  strobe_t          strb;
  logic [EVT_W-1:0] statusQ;
  logic [EVT_W-1:0] irqEnQ;
  logic [EVT_W-1:0] wakeEnQ;

  tmrevt_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busWrEn (busWrEn),
    .busAddr (busAddr),
    .strb    (strb)
  );

  tmrevt_datapath #(.EVT_W(EVT_W), .DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wrData    (busWrData),
    .evtIn     (evtIn),
    .rdData    (busRdData),
    .irqOut    (irqOut),
    .wakePulse (wakePulse),
    .captRearm (captRearm),
    .statusQ   (statusQ),
    .irqEnQ    (irqEnQ),
    .wakeEnQ   (wakeEnQ)
  );
endmodule

// File: rtl/tmrevt_checker.sv
module tmrevt_checker #(
  parameter int unsigned EVT_W  = 3,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [EVT_W-1:0]  evtIn,
  input logic              busWrEn,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWrData,
  input logic [EVT_W-1:0]  statusQ,
  input logic [EVT_W-1:0]  irqEnQ,
  input logic [EVT_W-1:0]  wakeEnQ,
  input logic              irqOut,
  input logic              wakePulse,
  input logic              captRearm
);
  logic flagWr;
  assign flagWr = busWrEn && (busAddr == '0);

  // R2
  flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((statusQ & ~$past(statusQ)) & ~$past(evtIn & irqEnQ)) == '0);

  // R3
  irq_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == (statusQ != '0));

  // R4
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    flagWr |=> (statusQ & $past(busWrData[EVT_W-1:0] & ~(evtIn & irqEnQ))) == '0);

  // R5
  rearm_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flagWr && busWrData[2]) |=> captRearm);

  // R5
  rearm_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(captRearm) |-> $past(flagWr && busWrData[2]));

  // R6
  wake_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((evtIn & wakeEnQ) != '0) |=> wakePulse);

  // R6
  wake_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse |-> $past((evtIn & wakeEnQ) != '0));

  // R8
  evt_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evtIn & irqEnQ) != '0 |=> (statusQ & $past(evtIn & irqEnQ)) == $past(evtIn & irqEnQ));
endmodule

bind tmrevt_top tmrevt_checker #(.EVT_W(EVT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .evtIn     (evtIn),
  .busWrEn   (busWrEn),
  .busAddr   (busAddr),
  .busWrData (busWrData),
  .statusQ   (statusQ),
  .irqEnQ    (irqEnQ),
  .wakeEnQ   (wakeEnQ),
  .irqOut    (irqOut),
  .wakePulse (wakePulse),
  .captRearm (captRearm)
);

// File: tb/sim_tmrevt_top.sv
module sim_tmrevt_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  evtIn = '0;
  logic        busWrEn = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        irqOut, wakePulse, captRearm;

  int nChk = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tmrevt_top u0 (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .busWrEn(busWrEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .irqOut(irqOut), .wakePulse(wakePulse), .captRearm(captRearm)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // All tasks are entered and left at a falling edge
  task automatic wr(logic [3:0] a, logic [31:0] d);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    busAddr = a;
    #1 d = busRdData;
  endtask

  task automatic pulse(logic [2:0] e);
    evtIn = e;
    @(negedge clk);
    evtIn = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFail++; nChk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(4'h0, r); chk("R1 flags", r, 0);
    rd(4'h4, r); chk("R1 irq mask", r, 0);
    rd(4'h8, r); chk("R1 wake mask", r, 0);
    chk("R1 irqOut", irqOut, 0);
    chk("R1 wakePulse", wakePulse, 0);
    chk("R1 captRearm", captRearm, 0);

    // Sweep every interrupt mask against every event pattern
    for (int ien = 0; ien < 8; ien++) begin
      logic [2:0] wen;
      wen = 3'(ien) ^ 3'b101;
      wr(4'h4, 32'hFFFF_FFF8 | 32'(ien));
      wr(4'h8, 32'hABCD_0000 | 32'(wen));
      rd(4'h4, r); chk("R7 irq mask masked", r, 32'(ien));
      rd(4'h8, r); chk("R7 wake mask masked", r, 32'(wen));
      for (int ev = 0; ev < 8; ev++) begin
        logic [2:0] expF;
        wr(4'h0, 32'h7);
        chk("R4 flags cleared irq", irqOut, 0);
        expF = 3'(ev) & 3'(ien);
        pulse(3'(ev));
        rd(4'h0, r); chk("R2 flag latch", r, 32'(expF));
        chk("R3 irq level", irqOut, 32'(expF != 0));
        chk("R6 wake pulse", wakePulse, 32'((3'(ev) & wen) != 0));
        @(negedge clk);
        chk("R6 wake one cycle", wakePulse, 0);
        rd(4'h0, r); chk("R6 flags kept", r, 32'(expF));
      end
    end

    // R4 partial clears
    wr(4'h4, 32'h7);
    wr(4'h0, 32'h7);
    pulse(3'b111);
    wr(4'h0, 32'h2);
    rd(4'h0, r); chk("R4 partial clear", r, 32'h5);
    chk("R4 irq still high", irqOut, 1);
    wr(4'h0, 32'h5);
    rd(4'h0, r); chk("R4 full clear", r, 0);
    chk("R4 irq dropped", irqOut, 0);

    // R5 capture rearm strobe
    wr(4'h0, 32'h4);
    chk("R5 rearm pulse", captRearm, 1);
    @(negedge clk);
    chk("R5 rearm one cycle", captRearm, 0);
    wr(4'h0, 32'h3);
    chk("R5 no rearm without bit2", captRearm, 0);
    wr(4'h4, 32'h4);
    chk("R5 no rearm on mask write", captRearm, 0);

    // R8 event and clear on the same flag
    wr(4'h4, 32'h7);
    pulse(3'b111);
    evtIn = 3'b001;
    wr(4'h0, 32'h1);
    evtIn = '0;
    rd(4'h0, r); chk("R8 event wins", r, 32'h7);
    evtIn = 3'b100;
    wr(4'h0, 32'h6);
    evtIn = '0;
    rd(4'h0, r); chk("R8 event wins others cleared", r, 32'h5);

    // R9 unmapped offset
    wr(4'hC, 32'hFFFF_FFFF);
    rd(4'hC, r); chk("R9 unmapped read", r, 0);
    rd(4'h0, r); chk("R9 flags untouched", r, 32'h5);
    rd(4'h4, r); chk("R9 irq mask untouched", r, 32'h7);
    rd(4'h8, r); chk("R9 wake mask untouched", r, 32'h2);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule